// File: doc/BRIEF.md
# Packet Frame Post Office

This block keeps track of packets held in a shared buffer memory on a board with four processor ports and one memory-unit port, joined to other boards by a packet-switched backplane. A packet lives in a fixed-size frame of the buffer and is passed between queues only as its frame number. The block holds a last-in first-out pool of free frames, one first-in first-out input queue for each local destination, two send queues that take turns as the active transmit queue and the resend queue, and one holding register for a packet being built over several accesses.

Every access arrives on a single command port, one per cycle; arbitration between the local masters that share that port lies outside the block. A posted packet is routed by decoding its first word. Packets for this board go straight into the right input queue. Packets for other boards go into the active send queue. The backplane transmitter reports each transfer as accepted or refused. A refused frame waits in the resend queue, and the two send queues exchange roles once the active one has drained. A packet arriving from the backplane gets the sender's board number written into its first word before it is queued locally.

Top module: `pkt_post_office`

## Requirements
- R1: After reset all queues are empty and `tx_pending` is 0. The free pool holds every frame, and successive claims hand out frames NFRAMES-1, NFRAMES-2 and so on downwards.
- R2: Word `s` of frame `f` lives at buffer address {f, s}. A word written there, all 34 bits including the last-word marker in bit 33, is returned by READ (op 6) with `cmd_frame`=f and `cmd_sub`=s.
- R3: A posted packet whose first word has board field (bits 25:21) equal to MY_BOARD and opcode field (bits 30:26) equal to zero enters processor queue 0 to 3, chosen by bits 32:31. TAKE (op 5) with `cmd_port` naming a queue returns its head frame on `rd_frame`.
- R4: A local packet with a nonzero opcode enters the memory-unit queue (`cmd_port` 4), whatever its processor field holds.
- R5: A packet whose board field differs from MY_BOARD enters the active send queue, whose head appears on `tx_frame` with `tx_pending` high. A local packet never enters a send queue.
- R6: RX_POST (op 9) overwrites bits 25:21 of word 0 of `cmd_frame` with `cmd_board`, keeps its other bits, and routes the frame to a local queue by opcode and processor field, whatever the old board field held.
- R7: Each queue delivers frames in the order they were pushed.
- R8: RELEASE (op 7) pushes `cmd_frame` onto the free pool, and the next claim returns that frame.
- R9: ONESHOT (op 4) claims the top free frame, writes `cmd_wdata` to sub-word 0 of it and routes it by that word, all in one accepted command.
- R10: TX_DONE (op 10) removes the head of the active send queue. With `cmd_nack`=1 the frame goes to the resend queue, and with `cmd_nack`=0 it goes to the free pool. When the active queue is empty and the resend queue is not, the roles swap, so the resent frame appears on `tx_frame`.
- R11: CLAIM (op 1), ONESHOT and GRAB (op 11) with an empty free pool, TAKE from an empty queue, and TX_DONE with nothing pending all raise `cmd_fail` and change no state.
- R12: A command that would push into a full queue drives `cmd_ready` low and changes no state.
- R13: CLAIM stores the claimed frame in the holding register while writing `cmd_wdata` at sub-word `cmd_sub`. WRITE (op 2) writes into the held frame, and POST (op 3) routes the held frame by its word 0. GRAB returns a frame on `rd_frame` without touching the holding register, and WRITE_AT (op 8) writes at {`cmd_frame`, `cmd_sub`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_port | input | 3 | Local queue for TAKE: 0-3 processors, 4 memory unit |
| cmd_frame | input | FRAME_BITS | Frame for READ, RELEASE, WRITE_AT, RX_POST |
| cmd_sub | input | SUB_BITS | Word within the frame |
| cmd_wdata | input | 34 | Word to write; bit 33 marks the last word |
| cmd_board | input | 5 | Sending board number for RX_POST |
| cmd_nack | input | 1 | TX_DONE: the receiver had no free frame |
| cmd_ready | output | 1 | Low when the command's target queue is full |
| cmd_fail | output | 1 | Command refused with no state change |
| rd_frame | output | FRAME_BITS | Claimed frame, or head frame for TAKE |
| rd_data | output | 34 | Buffer word at {cmd_frame, cmd_sub} |
| tx_pending | output | 1 | Active send queue not empty |
| tx_frame | output | FRAME_BITS | Head frame of the active send queue |

## Verification
The bench builds the block with eight frames of four words, a queue depth of two and board number 3. With eight frames the free pool can be emptied by a short run of claims, which reaches the refusal path, and with a depth of two a queue fills after two posts, which reaches the stall path. The same small sizes let a refused transmission and a later accepted one bring about a send-queue swap within a few commands.

// File: rtl/pkt_post_office.sv
module pkt_post_office #(
  parameter int FRAME_BITS = 3,
  parameter int SUB_BITS   = 2,
  parameter int QDEPTH     = 2,
  parameter logic [4:0] MY_BOARD = 5'd3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [3:0]            cmd_op,
  input  logic [2:0]            cmd_port,
  input  logic [FRAME_BITS-1:0] cmd_frame,
  input  logic [SUB_BITS-1:0]   cmd_sub,
  input  logic [33:0]           cmd_wdata,
  input  logic [4:0]            cmd_board,
  input  logic                  cmd_nack,
  output logic                  cmd_ready,
  output logic                  cmd_fail,
  output logic [FRAME_BITS-1:0] rd_frame,
  output logic [33:0]           rd_data,
  output logic                  tx_pending,
  output logic [FRAME_BITS-1:0] tx_frame
);
  localparam int FB = FRAME_BITS;
  localparam int AB = FRAME_BITS + SUB_BITS;
  localparam int NFRAMES = 1 << FB;
  localparam int NWORDS = 1 << AB;
  localparam int PW = $clog2(QDEPTH);
  localparam int QW = $clog2(QDEPTH + 1);
  localparam logic [3:0] OP_CLAIM = 4'd1, OP_WRITE = 4'd2, OP_POST = 4'd3,
    OP_ONESHOT = 4'd4, OP_TAKE = 4'd5, OP_RELEASE = 4'd7,
    OP_WRITE_AT = 4'd8, OP_RX_POST = 4'd9, OP_TX_DONE = 4'd10, OP_GRAB = 4'd11;

  logic [33:0]    mem [NWORDS];
  logic [FB-1:0]  fstk [NFRAMES];
  logic [FB:0]    fcnt;
  logic [FB-1:0]  temp;
  logic           sel;
  logic [FB-1:0]  qm [7][QDEPTH];
  logic [PW-1:0]  qh [7];
  logic [PW-1:0]  qt [7];
  logic [QW-1:0]  qc [7];

  logic [QW-1:0] cnt_a, cnt_b;
  logic act, free_empty, go, need_free, fail, push_v, pop_v, fs_pop, fs_push, mem_we;
  logic [2:0] aq, rq, pidx, dq, push_q, pop_q;
  logic [FB-1:0] free_top, push_d, fs_d;
  logic [AB-1:0] mem_a;
  logic [33:0] mem_d, hdr, w_temp, w_rx;

  assign cnt_a = qc[5];
  assign cnt_b = qc[6];
  assign act = sel ? !(cnt_b == '0 && cnt_a != '0) : (cnt_a == '0 && cnt_b != '0);
  assign aq = act ? 3'd6 : 3'd5;
  assign rq = act ? 3'd5 : 3'd6;
  assign tx_pending = qc[aq] != '0;
  assign tx_frame = qm[aq][qh[aq]];
  assign free_empty = fcnt == '0;
  assign free_top = fstk[fcnt[FB-1:0] - 1'b1];
  assign pidx = (cmd_port > 3'd4) ? 3'd0 : cmd_port;
  assign w_temp = mem[{temp, {SUB_BITS{1'b0}}}];
  assign w_rx = mem[{cmd_frame, {SUB_BITS{1'b0}}}];
  assign hdr = (cmd_op == OP_ONESHOT) ? cmd_wdata : (cmd_op == OP_RX_POST) ? w_rx : w_temp;
  assign dq = (cmd_op != OP_RX_POST && hdr[25:21] != MY_BOARD) ? aq :
              (hdr[30:26] == 5'd0) ? {1'b0, hdr[32:31]} : 3'd4;
  assign rd_frame = (cmd_op == OP_TAKE) ? qm[pidx][qh[pidx]] : free_top;
  assign rd_data = mem[{cmd_frame, cmd_sub}];

  always_comb begin
    need_free = 1'b0; fail = 1'b0;
    push_v = 1'b0; push_q = 3'd0; push_d = '0;
    pop_v = 1'b0; pop_q = 3'd0;
    fs_pop = 1'b0; fs_push = 1'b0; fs_d = '0;
    mem_we = 1'b0; mem_a = '0; mem_d = '0;
    case (cmd_op)
      OP_CLAIM: begin
        need_free = 1'b1; fs_pop = 1'b1;
        mem_we = 1'b1; mem_a = {free_top, cmd_sub}; mem_d = cmd_wdata;
      end
      OP_WRITE: begin
        mem_we = 1'b1; mem_a = {temp, cmd_sub}; mem_d = cmd_wdata;
      end
      OP_POST: begin
        push_v = 1'b1; push_q = dq; push_d = temp;
      end
      OP_ONESHOT: begin
        need_free = 1'b1; fs_pop = 1'b1;
        mem_we = 1'b1; mem_a = {free_top, {SUB_BITS{1'b0}}}; mem_d = cmd_wdata;
        push_v = 1'b1; push_q = dq; push_d = free_top;
      end
      OP_TAKE: begin
        fail = cmd_port > 3'd4 || qc[pidx] == '0;
        pop_v = 1'b1; pop_q = pidx;
      end
      OP_RELEASE: begin
        fs_push = 1'b1; fs_d = cmd_frame;
      end
      OP_WRITE_AT: begin
        mem_we = 1'b1; mem_a = {cmd_frame, cmd_sub}; mem_d = cmd_wdata;
      end
      OP_RX_POST: begin
        mem_we = 1'b1; mem_a = {cmd_frame, {SUB_BITS{1'b0}}};
        mem_d = {w_rx[33:26], cmd_board, w_rx[20:0]};
        push_v = 1'b1; push_q = dq; push_d = cmd_frame;
      end
      OP_TX_DONE: begin
        fail = !tx_pending;
        pop_v = 1'b1; pop_q = aq;
        if (cmd_nack) begin
          push_v = 1'b1; push_q = rq; push_d = tx_frame;
        end else begin
          fs_push = 1'b1; fs_d = tx_frame;
        end
      end
      OP_GRAB: begin
        need_free = 1'b1; fs_pop = 1'b1;
      end
      default: ;
    endcase
    if (need_free && free_empty) fail = 1'b1;
  end

  assign cmd_ready = !(push_v && qc[push_q] == QW'(QDEPTH));
  assign cmd_fail = cmd_valid && fail;
  assign go = cmd_valid && cmd_ready && !fail;

  for (genvar q = 0; q < 7; q++) begin : g_q
    logic push, pop;
    assign push = go && push_v && push_q == 3'(q);
    assign pop = go && pop_v && pop_q == 3'(q);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        qh[q] <= '0; qt[q] <= '0; qc[q] <= '0;
      end else begin
        if (push) qt[q] <= qt[q] + 1'b1;
        if (pop) qh[q] <= qh[q] + 1'b1;
        qc[q] <= qc[q] + QW'(push) - QW'(pop);
      end
    always_ff @(posedge clk)
      if (push) qm[q][qt[q]] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NFRAMES; i++) fstk[i] <= FB'(i);
      fcnt <= (FB+1)'(NFRAMES);
      temp <= '0;
      sel <= 1'b0;
    end else begin
      sel <= act;
      if (go && fs_pop) fcnt <= fcnt - 1'b1;
      if (go && fs_push) begin
        fstk[fcnt[FB-1:0]] <= fs_d;
        fcnt <= fcnt + 1'b1;
      end
      if (go && cmd_op == OP_CLAIM) temp <= free_top;
    end

  always_ff @(posedge clk)
    if (go && mem_we) mem[mem_a] <= mem_d;
endmodule

// File: rtl/pkt_post_office_chk.sv
module pkt_post_office_chk #(
  parameter int FB = 3,
  parameter int QW = 2,
  parameter int QDEPTH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          cmd_ready,
  input logic          cmd_fail,
  input logic [FB:0]   fcnt,
  input logic          sel,
  input logic [QW-1:0] cnt_a,
  input logic [QW-1:0] cnt_b
);
  localparam int NFRAMES = 1 << FB;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_a <= QW'(QDEPTH) && cnt_b <= QW'(QDEPTH)) else $error("send queue overflow"); // R12
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= (FB+1)'(NFRAMES)) else $error("free pool overflow"); // R8
  AST_EMPTY_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && fcnt == '0 && (cmd_op == 4'd1 || cmd_op == 4'd4 || cmd_op == 4'd11)) |-> cmd_fail)
    else $error("claim on empty pool not refused"); // R11
  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_fail) |=> ($stable(fcnt) && $stable(cnt_a) && $stable(cnt_b)))
    else $error("refused command changed state"); // R11
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(fcnt) && $stable(cnt_a) && $stable(cnt_b)))
    else $error("stalled command changed state"); // R12
  AST_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel ? cnt_b : cnt_a) == '0 && (sel ? cnt_a : cnt_b) != '0) |=> (sel != $past(sel)))
    else $error("send queues did not swap"); // R10
endmodule

bind pkt_post_office pkt_post_office_chk #(.FB(FB), .QW(QW), .QDEPTH(QDEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .cmd_fail(cmd_fail), .fcnt(fcnt), .sel(sel),
  .cnt_a(cnt_a), .cnt_b(cnt_b));

// File: tb/pkt_post_office_tb_top.sv
`timescale 1ns/100ps
module pkt_post_office_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_nack = 0;
  logic [3:0] cmd_op = 0;
  logic [2:0] cmd_port = 0;
  logic [2:0] cmd_frame = 0;
  logic [1:0] cmd_sub = 0;
  logic [33:0] cmd_wdata = 0;
  logic [4:0] cmd_board = 0;
  logic cmd_ready, cmd_fail, tx_pending;
  logic [2:0] rd_frame, tx_frame;
  logic [33:0] rd_data;
  int tests = 0, fails = 0;
  bit done = 0;
  logic s_ready, s_fail;
  logic [2:0] s_frame;
  logic [33:0] s_data;

  localparam logic [3:0] CLAIM = 1, WRITE = 2, POST = 3, ONESHOT = 4, TAKE = 5,
    READ = 6, RELEASE = 7, WRITE_AT = 8, RX_POST = 9, TX_DONE = 10, GRAB = 11;

  localparam logic [36:0] VEC [6] = '{
    {3'd2, 1'b1, 2'd2, 5'd0, 5'd3, 21'h0A5},
    {3'd1, 1'b1, 2'd1, 5'd0, 5'd3, 21'h1B2},
    {3'd0, 1'b0, 2'd0, 5'd0, 5'd3, 21'h003},
    {3'd3, 1'b1, 2'd3, 5'd0, 5'd3, 21'h1FFFF},
    {3'd4, 1'b1, 2'd1, 5'd5, 5'd3, 21'h044},
    {3'd5, 1'b1, 2'd0, 5'd0, 5'd9, 21'h077}};

  pkt_post_office dut_i (.*);

  always #2.5 clk = ~clk;

  function automatic logic [33:0] hdr(input logic [1:0] pe, input logic [4:0] opc,
                                      input logic [4:0] brd);
    return {1'b1, pe, opc, brd, 21'h012};
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [2:0] port = 0, input logic [2:0] fr = 0,
                     input logic [1:0] sub = 0, input logic [33:0] wd = 0,
                     input logic [4:0] brd = 0, input logic nack = 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_port = port; cmd_frame = fr; cmd_sub = sub;
    cmd_wdata = wd; cmd_board = brd; cmd_nack = nack;
    #1;
    s_ready = cmd_ready; s_fail = cmd_fail; s_frame = rd_frame; s_data = rd_data;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(tx_pending, 0, "R1 tx_pending after reset");
    cmd(GRAB); chk(s_frame, 7, "R1 first claim frame");
    cmd(GRAB); chk(s_frame, 6, "R1 second claim frame");
    cmd(RELEASE, 0, 6); cmd(RELEASE, 0, 7);

    foreach (VEC[i]) begin
      logic [33:0] w = VEC[i][33:0];
      logic [2:0] eq = VEC[i][36:34];
      cmd(ONESHOT, 0, 0, 0, w);
      chk(s_fail, 0, "R9 oneshot accepted");
      chk(s_frame, 7, "R9 oneshot frame");
      if (eq < 5) begin
        chk(tx_pending, 0, "R5 local packet kept off send queue");
        cmd(TAKE, eq); chk(s_frame, 7, eq == 4 ? "R4 memory-unit queue" : "R3 processor queue");
        cmd(READ, 0, 7, 0); chk(s_data, w, "R9 word 0 written");
        cmd(RELEASE, 0, 7);
      end else begin
        chk(tx_pending, 1, "R5 remote packet pending");
        chk(tx_frame, 7, "R5 remote frame on tx");
        cmd(TX_DONE, 0, 0, 0, 0, 0, 0);
        chk(tx_pending, 0, "R10 ack empties send queue");
        cmd(GRAB); chk(s_frame, 7, "R10 ack returns frame to pool");
        cmd(RELEASE, 0, 7);
      end
    end

    cmd(CLAIM, 0, 0, 0, hdr(2'd1, 5'd0, 5'd3));
    cmd(WRITE, 0, 0, 2'd1, 34'h0_1234_5678);
    cmd(WRITE, 0, 0, 2'd3, 34'h2_DEAD_BEEF);
    cmd(READ, 0, 7, 2'd1); chk(s_data, 34'h0_1234_5678, "R2 read sub 1");
    cmd(READ, 0, 7, 2'd3); chk(s_data, 34'h2_DEAD_BEEF, "R2 read sub 3 with last bit");
    cmd(POST);
    cmd(TAKE, 1); chk(s_frame, 7, "R13 held frame posted");
    cmd(RELEASE, 0, 7);

    cmd(ONESHOT, 0, 0, 0, hdr(2'd0, 5'd0, 5'd3));
    cmd(ONESHOT, 0, 0, 0, hdr(2'd0, 5'd0, 5'd3));
    cmd(TAKE, 0); chk(s_frame, 7, "R7 first out");
    cmd(TAKE, 0); chk(s_frame, 6, "R7 second out");
    cmd(RELEASE, 0, 6); cmd(RELEASE, 0, 7);

    cmd(ONESHOT, 0, 0, 0, hdr(2'd2, 5'd3, 5'd3));
    cmd(ONESHOT, 0, 0, 0, hdr(2'd2, 5'd3, 5'd3));
    cmd(ONESHOT, 0, 0, 0, hdr(2'd2, 5'd3, 5'd3));
    chk(s_ready, 0, "R12 full queue stalls");
    cmd(GRAB); chk(s_frame, 5, "R12 stalled push claimed nothing");
    cmd(RELEASE, 0, 5);
    cmd(TAKE, 4); chk(s_frame, 7, "R12 queue head kept");
    cmd(TAKE, 4); chk(s_frame, 6, "R12 queue second kept");
    cmd(TAKE, 4); chk(s_fail, 1, "R12 stalled frame never queued");
    cmd(RELEASE, 0, 6); cmd(RELEASE, 0, 7);

    cmd(GRAB);
    cmd(WRITE_AT, 0, 7, 0, hdr(2'd2, 5'd0, 5'd3));
    cmd(RX_POST, 0, 7, 0, 0, 5'd17);
    cmd(TAKE, 2); chk(s_frame, 7, "R6 received packet routed");
    cmd(READ, 0, 7, 0); chk(s_data, hdr(2'd2, 5'd0, 5'd17), "R6 board field rewritten");
    cmd(WRITE_AT, 0, 7, 0, hdr(2'd0, 5'd6, 5'd20));
    cmd(RX_POST, 0, 7, 0, 0, 5'd1);
    chk(tx_pending, 0, "R6 received packet kept local");
    cmd(TAKE, 4); chk(s_frame, 7, "R6 received to memory unit");
    cmd(RELEASE, 0, 7);

    cmd(ONESHOT, 0, 0, 0, hdr(2'd0, 5'd0, 5'd12));
    cmd(ONESHOT, 0, 0, 0, hdr(2'd1, 5'd0, 5'd12));
    chk(tx_frame, 7, "R10 send head");
    cmd(TX_DONE, 0, 0, 0, 0, 0, 1);
    chk(tx_frame, 6, "R10 nack leaves next on active");
    cmd(TX_DONE, 0, 0, 0, 0, 0, 0);
    chk(tx_pending, 1, "R10 resend pending after swap");
    chk(tx_frame, 7, "R10 resent frame after swap");
    cmd(TX_DONE, 0, 0, 0, 0, 0, 0);
    chk(tx_pending, 0, "R10 all sent");
    cmd(TX_DONE); chk(s_fail, 1, "R11 tx_done with nothing pending");
    cmd(GRAB); chk(s_frame, 7, "R10 acked frames back in pool");
    cmd(RELEASE, 0, 7);

    for (int k = 7; k >= 0; k--) cmd(GRAB);
    chk(s_frame, 0, "R1 last frame handed out");
    cmd(GRAB); chk(s_fail, 1, "R11 grab on empty pool");
    cmd(CLAIM, 0, 0, 0, 34'h1); chk(s_fail, 1, "R11 claim on empty pool");
    cmd(ONESHOT, 0, 0, 0, hdr(2'd0, 5'd0, 5'd9)); chk(s_fail, 1, "R11 oneshot on empty pool");
    chk(tx_pending, 0, "R11 refused oneshot queued nothing");
    cmd(TAKE, 0); chk(s_fail, 1, "R11 take from empty queue");
    for (int k = 0; k < 8; k++) cmd(RELEASE, 0, 3'(k));
    cmd(GRAB); chk(s_frame, 7, "R11 pool intact after refusals");
    cmd(GRAB); chk(s_frame, 6, "R8 next below");
    cmd(RELEASE, 0, 7);
    cmd(GRAB); chk(s_frame, 7, "R8 released frame reclaimed");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule